// File: doc/BRIEF.md
# Legacy GPIO bank with inverted interrupt mask

This block is a bank of general-purpose pins behind a 32-bit register interface. The bank is 16 or 32 pins wide, chosen by a parameter. Software sets the output levels, the direction, and an ownership bit for each pin. A pin is driven only when its ownership bit claims it for the processor and its direction bit makes it an output. In every other case the output enable stays low, so another owner outside this block can use the pad.

Every pin passes through a synchronizer before anything else uses it. Each pin has one select bit that picks which edge it detects: rising or falling. A detected edge sets a sticky status bit. This happens whether or not the pin is masked. Software clears a status bit by writing 1 to it. The mask has inverted polarity: a 1 blocks the pin. The single interrupt output is high whenever at least one status bit is set and unmasked.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`.

Top module: `gpio_legacy_bank`

## Requirements
- R1: After reset, these values hold:
  - the mask register (offset 0x10) reads all ones over the bank width;
  - the direction register (0x08) reads all ones, so every pin is an input;
  - output data (0x04), edge select (0x0C), status (0x14) and ownership (0x18) read 0;
  - `pin_oe` and `irq` are low.
- R2: The output data (0x04), direction (0x08), edge select (0x0C), mask (0x10) and ownership (0x18) registers read back what was written, in bit i for pin i. Bits at or above the bank width read 0. Any other offset reads 0.
- R3: Offset 0x00 returns the pin levels two clock edges after they change, because of the two-stage synchronizer. Writes to 0x00 have no effect.
- R4: `pin_oe[i]` is 1 exactly when ownership bit i is 1 and direction bit i is 0. `pin_out[i]` equals output data bit i while `pin_oe[i]` is 1, and is 0 otherwise.
- R5: With edge select bit i at 1, a rising edge on pin i sets status bit i, and a falling edge does not.
- R6: With edge select bit i at 0, a falling edge on pin i sets status bit i, and a rising edge does not.
- R7: A detected edge on a masked pin still sets its status bit. `irq` stays low while every set status bit is masked.
- R8: `irq` is high exactly when some status bit is 1 and its mask bit is 0.
- R9: Writing to offset 0x14 clears the status bits written as 1. Bits written as 0 keep their value.
- R10: When an edge on pin i and a write of 1 to status bit i fall on the same clock edge, the status bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pin_in | input | PIN_COUNT | Pad input levels |
| pin_out | output | PIN_COUNT | Output levels |
| pin_oe | output | PIN_COUNT | Output enables |
| irq | output | 1 | Interrupt for any unmasked pending pin |

## Verification
The bench sweeps every pin through both edge polarities and checks that only the selected polarity latches. A design with the polarity swapped, or with one select bit shared between pins, would set the wrong status bits. The bench also checks edges that arrive while the pin is masked, and a clear that lands on the same clock edge as a new edge. A design that gated the status latch with the mask would lose the first case. A design that let the clear win would lose the second. The ownership and direction sweep covers all four combinations per pin, which exposes an output enable that ignores ownership. Zero writes to the status register, writes to the input register, and unmapped offsets are also checked, which catches a status register that is plainly writable.

// File: rtl/gpio_lb_pkg.sv
package gpio_lb_pkg;
   localparam int unsigned BUS_W  = 32;
   localparam int unsigned ADDR_W = 5;

   // register byte offsets
   typedef enum logic [ADDR_W-1:0] {
      OFS_LEVEL = 5'h00,
      OFS_DOUT  = 5'h04,
      OFS_DIR   = 5'h08,
      OFS_EDGE  = 5'h0C,
      OFS_MASK  = 5'h10,
      OFS_STAT  = 5'h14,
      OFS_OWN   = 5'h18
   } reg_ofs_e;
endpackage

// File: rtl/gpio_lb_sync.sv
module gpio_lb_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] raw_in,
   output logic [WIDTH-1:0] level,
   output logic [WIDTH-1:0] level_d
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_lb_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= raw_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   // one more register holds the previous synchronized level for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= '0;
      else        level_d <= stg[STAGES-1];
   end

   assign level = stg[STAGES-1];
endmodule

// File: rtl/gpio_lb_regs.sv
module gpio_lb_regs
   import gpio_lb_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [WIDTH-1:0]  dout_q,
   output logic [WIDTH-1:0]  dir_q,
   output logic [WIDTH-1:0]  edge_q,
   output logic [WIDTH-1:0]  mask_q,
   output logic [WIDTH-1:0]  own_q,
   output logic [WIDTH-1:0]  clr_vec
);
   logic [WIDTH-1:0] wval;
   assign wval = wdata[WIDTH-1:0];

   if (WIDTH < BUS_W) begin : g_hi_unused
      logic unused_hi;
      assign unused_hi = ^wdata[BUS_W-1:WIDTH];
   end

   logic we_dout, we_dir, we_edge, we_mask, we_own, we_stat;
   assign we_dout = wr_en && (addr == OFS_DOUT);
   assign we_dir  = wr_en && (addr == OFS_DIR);
   assign we_edge = wr_en && (addr == OFS_EDGE);
   assign we_mask = wr_en && (addr == OFS_MASK);
   assign we_own  = wr_en && (addr == OFS_OWN);
   assign we_stat = wr_en && (addr == OFS_STAT);

   assign clr_vec = we_stat ? wval : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q <= '0;
         dir_q  <= '1;
         edge_q <= '0;
         mask_q <= '1;
         own_q  <= '0;
      end else begin
         if (we_dout) dout_q <= wval;
         if (we_dir)  dir_q  <= wval;
         if (we_edge) edge_q <= wval;
         if (we_mask) mask_q <= wval;
         if (we_own)  own_q  <= wval;
      end
   end

   // R1
   mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mask_q == '1 && dir_q == '1 && own_q == '0));

   // R2
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_mask) |-> (mask_q == $past(wval)));
endmodule

// File: rtl/gpio_lb_status.sv
module gpio_lb_status #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] level,
   input  logic [WIDTH-1:0] level_d,
   input  logic [WIDTH-1:0] edge_sel,
   input  logic [WIDTH-1:0] mask,
   input  logic [WIDTH-1:0] clr_vec,
   output logic [WIDTH-1:0] status_q,
   output logic             irq
);
   logic [WIDTH-1:0] hit;

   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic rise, fall;
      assign rise   = level[i] & ~level_d[i];
      assign fall   = ~level[i] & level_d[i];
      assign hit[i] = edge_sel[i] ? rise : fall;

      // a fresh edge wins over a clear on the same edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      status_q[i] <= 1'b0;
         else if (hit[i]) status_q[i] <= 1'b1;
         else if (clr_vec[i]) status_q[i] <= 1'b0;
      end
   end

   assign irq = |(status_q & ~mask);

   // R10
   hit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & $past(hit)) == $past(hit)));

   // R9
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(clr_vec) == '0) |-> ((status_q & $past(status_q)) == $past(status_q)));

   // R7
   masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((status_q & ~mask) == '0) |-> !irq);
endmodule

// File: rtl/gpio_lb_drive.sv
module gpio_lb_drive #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH-1:0] dout,
   input  logic [WIDTH-1:0] dir,
   input  logic [WIDTH-1:0] own,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      assign pad_oe[i]  = own[i] & ~dir[i];
      assign pad_out[i] = pad_oe[i] & dout[i];
   end
endmodule

// File: rtl/gpio_legacy_bank.sv
module gpio_legacy_bank
   import gpio_lb_pkg::*;
#(
   parameter int unsigned PIN_COUNT   = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_wr,
   input  logic [BUS_W-1:0]     bus_wdata,
   output logic [BUS_W-1:0]     bus_rdata,
   input  logic [PIN_COUNT-1:0] pin_in,
   output logic [PIN_COUNT-1:0] pin_out,
   output logic [PIN_COUNT-1:0] pin_oe,
   output logic                 irq
);
   if (PIN_COUNT != 16 && PIN_COUNT != 32) begin : g_bad_width
      $error("gpio_legacy_bank: PIN_COUNT must be 16 or 32");
   end

   logic [PIN_COUNT-1:0] level, level_d;
   logic [PIN_COUNT-1:0] dout_q, dir_q, edge_q, mask_q, own_q, clr_vec, status_q;

   gpio_lb_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .level(level), .level_d(level_d));

   gpio_lb_regs #(.WIDTH(PIN_COUNT)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
      .dout_q(dout_q), .dir_q(dir_q), .edge_q(edge_q), .mask_q(mask_q),
      .own_q(own_q), .clr_vec(clr_vec));

   gpio_lb_status #(.WIDTH(PIN_COUNT)) u_status (
      .clk(clk), .rst_n(rst_n), .level(level), .level_d(level_d), .edge_sel(edge_q),
      .mask(mask_q), .clr_vec(clr_vec), .status_q(status_q), .irq(irq));

   gpio_lb_drive #(.WIDTH(PIN_COUNT)) u_drive (
      .dout(dout_q), .dir(dir_q), .own(own_q), .pad_out(pin_out), .pad_oe(pin_oe));

   always_comb begin
      logic [PIN_COUNT-1:0] sel;
      sel = '0;
      unique case (bus_addr)
         OFS_LEVEL: sel = level;
         OFS_DOUT:  sel = dout_q;
         OFS_DIR:   sel = dir_q;
         OFS_EDGE:  sel = edge_q;
         OFS_MASK:  sel = mask_q;
         OFS_STAT:  sel = status_q;
         OFS_OWN:   sel = own_q;
         default:   sel = '0;
      endcase
      bus_rdata = '0;
      bus_rdata[PIN_COUNT-1:0] = sel;
   end

   // R4
   oe_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pin_oe & (dir_q | ~own_q)) == '0));

   // R8
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status_q != '0));
endmodule

// File: tb/tb_gpio_legacy_bank.sv
module tb_gpio_legacy_bank;
   localparam int  CLK_PERIOD = 10;
   localparam int  N = 16;
   localparam logic [31:0] WMASK = 32'h0000_FFFF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [N-1:0] pin_in = '0;
   logic [N-1:0] pin_out, pin_oe;
   logic irq;
   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   gpio_legacy_bank #(.PIN_COUNT(N)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_pin(input int p, input logic v);
      @(negedge clk);
      pin_in[p] = v;
      repeat (4) @(posedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] pat;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(5'h10, d); chk("R1 mask", d, WMASK);
      rd(5'h08, d); chk("R1 dir", d, WMASK);
      rd(5'h04, d); chk("R1 dout", d, 0);
      rd(5'h0C, d); chk("R1 edge", d, 0);
      rd(5'h14, d); chk("R1 status", d, 0);
      rd(5'h18, d); chk("R1 own", d, 0);
      chk("R1 oe", {16'h0, pin_oe}, 0);
      chk("R1 irq", {31'h0, irq}, 0);

      // R2 readback, upper bits dropped, unmapped zero
      foreach (pat[k]) ;
      for (int r = 0; r < 5; r++) begin
         logic [4:0] a;
         a = (r == 0) ? 5'h04 : (r == 1) ? 5'h08 : (r == 2) ? 5'h0C : (r == 3) ? 5'h10 : 5'h18;
         for (int v = 0; v < 3; v++) begin
            pat = (v == 0) ? 32'hA5A5_5A5A : (v == 1) ? 32'h1234_C3E1 : 32'hFFFF_0000;
            wr(a, pat);
            rd(a, d); chk("R2 readback", d, pat & WMASK);
         end
      end
      rd(5'h1C, d); chk("R2 unmapped", d, 0);
      wr(5'h10, 32'hFFFF); wr(5'h0C, 0); wr(5'h18, 0); wr(5'h08, 32'hFFFF); wr(5'h04, 0);

      // R3 synchronized input, write ignored
      for (int v = 0; v < 4; v++) begin
         logic [15:0] lv;
         lv = 16'h1 << (v * 4) ^ 16'h8421 * v[15:0];
         @(negedge clk); pin_in = lv;
         @(posedge clk); @(posedge clk);
         #1 bus_addr = 5'h00; #1 chk("R3 level", bus_rdata, {16'h0, lv});
      end
      wr(5'h00, 32'h0000_FFFF);
      rd(5'h00, d); chk("R3 write ignored", d, {16'h0, pin_in});
      @(negedge clk); pin_in = '0;
      repeat (4) @(posedge clk);
      wr(5'h14, 32'hFFFF);

      // R4 ownership/direction gating
      wr(5'h18, 32'hF0F0); wr(5'h08, 32'hCCCC);
      for (int v = 0; v < 4; v++) begin
         logic [15:0] dv;
         dv = (v == 0) ? 16'hAAAA : (v == 1) ? 16'h5555 : (v == 2) ? 16'hFFFF : 16'h0000;
         wr(5'h04, {16'h0, dv});
         @(negedge clk);
         chk("R4 oe", {16'h0, pin_oe}, {16'h0, 16'hF0F0 & ~16'hCCCC});
         chk("R4 out", {16'h0, pin_out}, {16'h0, dv & 16'hF0F0 & ~16'hCCCC});
      end
      wr(5'h18, 0); wr(5'h08, 32'hFFFF); wr(5'h04, 0);

      // R5 / R6 / R7 sweep: every pin, both polarities, all masked
      for (int s = 0; s < 2; s++) begin
         wr(5'h0C, s ? 32'hFFFF : 32'h0);
         for (int p = 0; p < N; p++) begin
            set_pin(p, 1'b1);
            rd(5'h14, d);
            chk(s ? "R5 rise sets" : "R6 rise ignored", d, s ? (32'h1 << p) : 0);
            chk("R7 masked irq low", {31'h0, irq}, 0);
            wr(5'h14, 32'hFFFF);
            set_pin(p, 1'b0);
            rd(5'h14, d);
            chk(s ? "R5 fall ignored" : "R6 fall sets", d, s ? 0 : (32'h1 << p));
            wr(5'h14, 32'hFFFF);
         end
      end

      // R8 irq from unmasked status
      wr(5'h0C, 32'hFFFF);
      set_pin(3, 1'b1); set_pin(5, 1'b1);
      wr(5'h10, ~(32'h1 << 7));
      @(negedge clk); chk("R8 other pin unmasked", {31'h0, irq}, 0);
      wr(5'h10, ~(32'h1 << 3));
      @(negedge clk); chk("R8 pending unmasked", {31'h0, irq}, 1);
      wr(5'h10, 32'hFFFF);
      @(negedge clk); chk("R8 remasked", {31'h0, irq}, 0);
      rd(5'h14, d); chk("R7 status kept", d, 32'h28);

      // R9 write-one-to-clear
      wr(5'h14, 0);
      rd(5'h14, d); chk("R9 zero write", d, 32'h28);
      wr(5'h14, 32'h8);
      rd(5'h14, d); chk("R9 partial clear", d, 32'h20);
      wr(5'h14, 32'hFFFF);
      rd(5'h14, d); chk("R9 full clear", d, 0);

      // R10 edge and clear on same clock edge
      @(negedge clk); pin_in[9] = 1'b0; pin_in[3] = 1'b0; pin_in[5] = 1'b0;
      repeat (4) @(posedge clk);
      wr(5'h14, 32'hFFFF);
      @(negedge clk); pin_in[9] = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      bus_addr = 5'h14; bus_wdata = 32'h200; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
      rd(5'h14, d); chk("R10 edge beats clear", d, 32'h200);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule